// File: doc/BRIEF.md
# Single-Steppable Subtract-and-Count Divider

This block divides one unsigned operand by another by taking the divisor away from a running residue once per step and counting how many times that succeeds. A three-state controller sequences the work: an idle state waits for a start request, a busy state performs the subtractions, and a finished state holds the result until the requester acknowledges it. The controller and the datapath registers are updated together in a single clocked case statement.

Every transfer and every state change made in the busy state is qualified by a one-clock-wide step enable. With the enable held high, the divider advances one subtraction per clock. With the enable pulsed by a debounced button or a test controller, the divider advances one subtraction per pulse. This lets an observer watch the quotient and residue evolve. The idle and finished states are not gated by the step enable.

Each state is reported on its own flag output. The residue left when the loop stops is the remainder. A zero divisor is not trapped: the loop never exits, and the count wraps. Only reset leaves that condition.

Top module: `subloop_divider`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block enters the idle state: after that edge `in_idle` is 1 and `in_busy` and `in_done` are 0.
- R2: Exactly one of `in_idle`, `in_busy` and `in_done` is 1 at any time out of reset, and `done` always equals `in_done`.
- R3: In the idle state, a clock edge with `start` high loads the residue from `dividend` and the divisor from `divisor`, clears `quotient` to 0, and moves to the busy state. After that edge `remainder` shows `dividend`.
- R4: In the busy state, a clock edge with `step_en` high and residue not less than the divisor subtracts the divisor from the residue and adds 1 to `quotient`, both in that edge. With `step_en` held high, `done` therefore rises exactly q+1 clock edges after the loading edge, where q is the final quotient.
- R5: In the busy state, a clock edge with `step_en` high and residue less than the divisor moves the block to the finished state. `quotient` is then floor(dividend/divisor) and `remainder` is dividend mod divisor. For example, 0x58 / 0x04 gives 0x16 remainder 0x00.
- R6: In the busy state, a clock edge with `step_en` low changes neither the state, `quotient` nor `remainder`.
- R7: In the finished state, `quotient` and `remainder` stay stable and the state is held until `ack` is seen. `start` has no effect there.
- R8: In the finished state, a clock edge with `ack` high returns the block to idle. In the idle state, `ack` has no effect.
- R9: With a zero divisor, the block never leaves the busy state. `quotient` increments by one per enabled step, modulo 2^WIDTH, and `remainder` keeps the dividend value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to load the operands and begin, honoured in idle |
| ack | input | 1 | Acknowledge of the result, honoured in the finished state |
| step_en | input | 1 | One-clock enable that qualifies every busy-state step |
| dividend | input | WIDTH | Unsigned dividend |
| divisor | input | WIDTH | Unsigned divisor |
| quotient | output | WIDTH | Count of successful subtractions |
| remainder | output | WIDTH | Current residue; the remainder once finished |
| done | output | 1 | High while the result is being held |
| in_idle | output | 1 | Idle-state flag |
| in_busy | output | 1 | Busy-state flag |
| in_done | output | 1 | Finished-state flag |

## Verification
The bench goes after the loop-exit edges.

- **Equal operands.** A divider with the exit test written as less-or-equal would report a quotient one too small.
- **Dividend below the divisor.** The result must be a zero quotient with the dividend as the remainder.
- **Maximum quotient of 255.** A wrong count or a narrowed register would lose the top value.

The latency of every division is measured, so an extra or missing cycle in the loop is caught.

The bench also holds the step enable low in the middle of a division. A design that leaked a transfer past the enable would change the quotient or the residue while it should stall.

A zero divisor is run for 300 steps. The bench expects the block to stay busy with the quotient wrapped to 44. A design that trapped, stopped or saturated would show a different state or count.

Start pulses during the finished state and acknowledges during idle are applied, and they must leave the outputs untouched.

// File: rtl/subloop_div_pkg.sv
// Package: shared state encoding for the subtract-and-count divider.
// Assumes: three control states, encoded in two bits.
package subloop_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } div_state_t;

endpackage

// File: rtl/subloop_div_core.sv
// Module: combined control unit and datapath of the divider.
// The state register, the residue, the held divisor and the quotient
// counter are all updated from one clocked case statement.
// Assumes: unsigned operands; a zero divisor is not trapped (the loop spins).
module subloop_div_core
    import subloop_div_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ack,
    input  logic             step_en,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output div_state_t       state_o,
    output logic [WIDTH-1:0] quo_o,
    output logic [WIDTH-1:0] res_o
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    div_state_t       state;
    logic [WIDTH-1:0] res_q;
    logic [WIDTH-1:0] dvs_q;
    logic [WIDTH-1:0] quo_q;

    // Sequencing and data transfers; the data registers get don't-care on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            res_q <= 'x;
            dvs_q <= 'x;
            quo_q <= 'x;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        res_q <= dividend;
                        dvs_q <= divisor;
                        quo_q <= '0;
                        state <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (step_en) begin
                        if (res_q < dvs_q) begin
                            state <= ST_DONE;
                        end else begin
                            res_q <= res_q - dvs_q;
                            quo_q <= quo_q + ONE;
                        end
                    end
                end
                ST_DONE: begin
                    if (ack) begin
                        state <= ST_IDLE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Expose the registers unchanged.
    always_comb begin
        state_o = state;
        quo_o   = quo_q;
        res_o   = res_q;
    end

endmodule

// File: rtl/subloop_div_flags.sv
// Module: decodes the encoded control state into one flag per state.
// Assumes: the state value is always one of the three legal encodings.
module subloop_div_flags
    import subloop_div_pkg::*;
(
    input  div_state_t state,
    output logic       f_idle,
    output logic       f_busy,
    output logic       f_done
);

    // One flag per state; an illegal code raises none of them.
    always_comb begin
        f_idle = (state == ST_IDLE);
        f_busy = (state == ST_BUSY);
        f_done = (state == ST_DONE);
    end

endmodule

// File: rtl/subloop_divider.sv
// Module: top of the single-steppable subtract-and-count divider.
// Assumes: step_en is a one-clock enable pulse, or is tied high for full rate.
module subloop_divider
    import subloop_div_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ack,
    input  logic             step_en,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             done,
    output logic             in_idle,
    output logic             in_busy,
    output logic             in_done
);

    div_state_t state_w;
    logic       fin_w;

    subloop_div_core #(.WIDTH(WIDTH)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ack      (ack),
        .step_en  (step_en),
        .dividend (dividend),
        .divisor  (divisor),
        .state_o  (state_w),
        .quo_o    (quotient),
        .res_o    (remainder)
    );

    subloop_div_flags u_flags (
        .state  (state_w),
        .f_idle (in_idle),
        .f_busy (in_busy),
        .f_done (fin_w)
    );

    // The done output mirrors the finished-state flag.
    always_comb begin
        in_done = fin_w;
        done    = fin_w;
    end

endmodule

// File: rtl/subloop_div_checker.sv
// Module: port-level property checker for the divider, attached by bind.
// Assumes: it sees only the top-level ports.
module subloop_div_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             ack,
    input logic             step_en,
    input logic [WIDTH-1:0] dividend,
    input logic [WIDTH-1:0] quotient,
    input logic [WIDTH-1:0] remainder,
    input logic             done,
    input logic             in_idle,
    input logic             in_busy,
    input logic             in_done
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (in_idle && !in_busy && !in_done)); // R1

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({in_idle, in_busy, in_done}) && (done == in_done)); // R2

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && start) |=> (in_busy && quotient == '0 && remainder == $past(dividend))); // R3

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_busy && step_en) |=> ((in_done && $stable(quotient) && $stable(remainder))
            || (in_busy && quotient == WIDTH'($past(quotient) + 1'b1)))); // R4

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_busy && !step_en) |=> (in_busy && $stable(quotient) && $stable(remainder))); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_done && !ack) |=> (in_done && $stable(quotient) && $stable(remainder))); // R7

    AST_ACK_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_done && ack) |=> in_idle); // R8

    AST_IDLE_IGNORES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && !start) |=> in_idle); // R8

endmodule

bind subloop_divider subloop_div_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ack       (ack),
    .step_en   (step_en),
    .dividend  (dividend),
    .quotient  (quotient),
    .remainder (remainder),
    .done      (done),
    .in_idle   (in_idle),
    .in_busy   (in_busy),
    .in_done   (in_done)
);

// File: tb/tb_subloop_divider.sv
// Bench: vector table of divisions at full rate, then directed tests for
// reset, single stepping, result hold, acknowledge and a zero divisor.
module tb_subloop_divider;

    localparam int W = 8;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] q;
        logic [W-1:0] r;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h58, 8'h04, 8'h16, 8'h00},
        '{8'h07, 8'h03, 8'h02, 8'h01},
        '{8'h03, 8'h07, 8'h00, 8'h03},
        '{8'hFF, 8'h01, 8'hFF, 8'h00},
        '{8'h00, 8'h05, 8'h00, 8'h00},
        '{8'h64, 8'h0A, 8'h0A, 8'h00},
        '{8'hC8, 8'h0B, 8'h12, 8'h02},
        '{8'h10, 8'h10, 8'h01, 8'h00}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         ack = 1'b0;
    logic         step_en = 1'b1;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         done;
    logic         in_idle;
    logic         in_busy;
    logic         in_done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    subloop_divider #(.WIDTH(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ack       (ack),
        .step_en   (step_en),
        .dividend  (dividend),
        .divisor   (divisor),
        .quotient  (quotient),
        .remainder (remainder),
        .done      (done),
        .in_idle   (in_idle),
        .in_busy   (in_busy),
        .in_done   (in_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_flags(input string req, input bit i, input bit b, input bit d);
        check(in_idle == i && in_busy == b && in_done == d && done == d, req,
              "flags {idle,busy,done,done_out}", {in_idle, in_busy, in_done, done},
              {i, b, d, d});
    endtask

    task automatic load(input logic [W-1:0] a, input logic [W-1:0] b);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        tick();
        start    = 1'b0;
        check_flags("R3", 1'b0, 1'b1, 1'b0);
        check(quotient == '0, "R3", "quotient after load", quotient, 0);
        check(remainder == a, "R3", "residue after load", remainder, a);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick();
        check_flags("R1", 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        tick();

        for (int k = 0; k < NV; k++) begin
            int cnt;
            load(VECS[k].a, VECS[k].b);
            cnt = 0;
            while (!done && cnt < 400) begin
                tick();
                cnt++;
            end
            check(cnt == int'(VECS[k].q) + 1, "R4", "latency in cycles", cnt,
                  int'(VECS[k].q) + 1);
            check(quotient == VECS[k].q, "R5", "quotient", quotient, VECS[k].q);
            check(remainder == VECS[k].r, "R5", "remainder", remainder, VECS[k].r);
            check_flags("R2", 1'b0, 1'b0, 1'b1);
            // R7: start is ignored in the finished state and the result holds
            start    = 1'b1;
            dividend = 8'hAA;
            tick();
            tick();
            start = 1'b0;
            check_flags("R7", 1'b0, 1'b0, 1'b1);
            check(quotient == VECS[k].q && remainder == VECS[k].r, "R7",
                  "held {q,r}", {quotient, remainder}, {VECS[k].q, VECS[k].r});
            ack = 1'b1;
            tick();
            ack = 1'b0;
            check_flags("R8", 1'b1, 1'b0, 1'b0);
        end

        // R8: ack in idle does nothing
        ack = 1'b1;
        tick();
        tick();
        ack = 1'b0;
        check_flags("R8", 1'b1, 1'b0, 1'b0);

        // R6 and R4: single stepping 7 / 2
        step_en = 1'b0;
        load(8'h07, 8'h02);
        for (int s = 0; s < 5; s++) tick();
        check_flags("R6", 1'b0, 1'b1, 1'b0);
        check(quotient == 8'd0 && remainder == 8'd7, "R6", "stalled {q,r}",
              {quotient, remainder}, {8'd0, 8'd7});
        step_en = 1'b1;
        tick();
        step_en = 1'b0;
        check(quotient == 8'd1 && remainder == 8'd5, "R4", "one step {q,r}",
              {quotient, remainder}, {8'd1, 8'd5});
        for (int s = 0; s < 3; s++) tick();
        check(quotient == 8'd1 && remainder == 8'd5, "R6", "stalled again {q,r}",
              {quotient, remainder}, {8'd1, 8'd5});
        for (int s = 0; s < 3; s++) begin
            step_en = 1'b1;
            tick();
            step_en = 1'b0;
            tick();
        end
        check_flags("R5", 1'b0, 1'b0, 1'b1);
        check(quotient == 8'd3 && remainder == 8'd1, "R5", "stepped result {q,r}",
              {quotient, remainder}, {8'd3, 8'd1});
        step_en = 1'b1;
        ack = 1'b1;
        tick();
        ack = 1'b0;
        check_flags("R8", 1'b1, 1'b0, 1'b0);

        // R9: zero divisor spins and wraps, 300 steps -> 44
        load(8'h09, 8'h00);
        for (int s = 0; s < 300; s++) tick();
        check_flags("R9", 1'b0, 1'b1, 1'b0);
        check(quotient == 8'd44, "R9", "wrapped quotient", quotient, 44);
        check(remainder == 8'h09, "R9", "residue", remainder, 9);

        // R1: reset out of the busy state
        rst_n = 1'b0;
        tick();
        check_flags("R1", 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        tick();
        check_flags("R1", 1'b1, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule